// File: doc/BRIEF.md
# Ring Token Bus Arbiter

This block decides which of several processing nodes may drive a shared system bus. The nodes form a logical ring and one token travels around it. The node that holds the token owns the bus for a whole block transfer, which may last many cycles. A typical transfer is a node copying its local frame buffers into a global frame buffer. Ownership changes only when the current owner reports that its transfer is complete. The token then moves to the next node in ring order.

Each node drives a request line and a transfer-done line, and receives a grant line. A node that holds the token but has no request passes the token on after one cycle, so idle nodes add a small, fixed delay. There is no priority and no preemption. The block also outputs the token position so the current custodian can be observed.

Top module: `token_ring_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, the token is at node 0 (`token_o` = 4'b0001 with the default of four nodes) and `grant_o` is all-zero.
- R2: When the token sits at node k with no grant and `req_i[k]` is low at the clock edge, the token is at node k+1 (modulo the node count) in the next cycle, and no grant is raised.
- R3: When the token sits at node k with no grant and `req_i[k]` is high at the clock edge, `grant_o[k]` is high from the next cycle.
- R4: A raised grant stays high, and the token stays put, in every cycle until the holder's own `done_i` bit is sampled high. This holds even if the holder drops its request.
- R5: When the holder's `done_i` bit is sampled high, `grant_o` is all-zero in the next cycle and the token has moved to the next node in ring order.
- R6: `done_i` bits from nodes that do not hold a grant have no effect on the grant or on the token position.
- R7: `grant_o` is one-hot or all-zero in every cycle.
- R8: The token visits nodes in increasing index order and wraps from the highest index to node 0.
- R9: `token_o` is exactly one-hot in every cycle.
- R10: A grant bit is high only at the node where the token bit is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | NODES | Per-node bus request |
| done_i | input | NODES | Per-node end-of-transfer pulse |
| grant_o | output | NODES | Per-node bus grant |
| token_o | output | NODES | One-hot position of the token |

## Verification
The assertions assume that a node pulses its done bit for one cycle, and only while its own grant is high. A done bit that arrives without a grant is expected to be ignored, and the properties are written so that such a stray pulse cannot break them. The stimulus works out the holder from the bench's own model. It raises the holder's done bit only as a single pulse, and it sends stray done pulses only to nodes that do not hold a grant. This lets those cases exercise R6 while staying inside the assumed input behaviour. Requests are changed freely, including being dropped in the middle of a grant, because the block must tolerate that.

// File: rtl/tring_pkg.sv
package tring_pkg;

    // Whether the token is checking its node for a request, or its node owns the bus.
    typedef enum logic {
        PH_PROBE = 1'b0,
        PH_OWN   = 1'b1
    } phase_e;

    // What the keeper does with the token in this cycle.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SEIZE = 2'd1,
        ACT_PASS  = 2'd2
    } action_e;

    // One step of token custody, decided from the signals at the token's current node.
    function automatic action_e decide(phase_e ph, logic req_here, logic done_here);
        action_e a;
        if (ph == PH_PROBE) begin
            a = req_here ? ACT_SEIZE : ACT_PASS;
        end else begin
            a = done_here ? ACT_PASS : ACT_HOLD;
        end
        return a;
    endfunction

endpackage

// File: rtl/tring_select.sv
module tring_select #(
    parameter int NODES = 4,
    localparam int IW = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic [NODES-1:0] req_i,
    input  logic [NODES-1:0] done_i,
    input  logic [IW-1:0]    pos_i,
    output logic             req_here_o,
    output logic             done_here_o
);

    always_comb begin
        req_here_o  = 1'b0;
        done_here_o = 1'b0;
        for (int i = 0; i < NODES; i++) begin
            if (pos_i == IW'(i)) begin
                req_here_o  = req_i[i];
                done_here_o = done_i[i];
            end
        end
    end

endmodule

// File: rtl/tring_keeper.sv
module tring_keeper
    import tring_pkg::*;
#(
    parameter int NODES = 4,
    localparam int IW = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_here_i,
    input  logic          done_here_i,
    output logic [IW-1:0] pos_o,
    output phase_e        phase_o
);

    localparam logic [IW-1:0] LAST = IW'(NODES - 1);

    logic [IW-1:0] pos_q;
    logic [IW-1:0] pos_next;
    phase_e        phase_q;
    action_e       act;

    assign act      = decide(phase_q, req_here_i, done_here_i);
    assign pos_next = (pos_q == LAST) ? '0 : pos_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            phase_q <= PH_PROBE;
        end else begin
            case (act)
                ACT_SEIZE: phase_q <= PH_OWN;
                ACT_PASS: begin
                    phase_q <= PH_PROBE;
                    pos_q   <= pos_next;
                end
                default: ;
            endcase
        end
    end

    assign pos_o   = pos_q;
    assign phase_o = phase_q;

endmodule

// File: rtl/tring_decode.sv
module tring_decode
    import tring_pkg::*;
#(
    parameter int NODES = 4,
    localparam int IW = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic [IW-1:0]    pos_i,
    input  phase_e           phase_i,
    output logic [NODES-1:0] grant_o,
    output logic [NODES-1:0] token_o
);

    for (genvar g = 0; g < NODES; g++) begin : g_node
        assign token_o[g] = (pos_i == IW'(g));
        assign grant_o[g] = token_o[g] && (phase_i == PH_OWN);
    end

endmodule

// File: rtl/token_ring_arbiter.sv
module token_ring_arbiter
    import tring_pkg::*;
#(
    parameter int NODES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NODES-1:0] req_i,
    input  logic [NODES-1:0] done_i,
    output logic [NODES-1:0] grant_o,
    output logic [NODES-1:0] token_o
);

    localparam int IW = (NODES > 1) ? $clog2(NODES) : 1;

    logic [IW-1:0] pos;
    phase_e        phase;
    logic          req_here;
    logic          done_here;

    tring_select #(.NODES(NODES)) u_select (
        .req_i       (req_i),
        .done_i      (done_i),
        .pos_i       (pos),
        .req_here_o  (req_here),
        .done_here_o (done_here)
    );

    tring_keeper #(.NODES(NODES)) u_keeper (
        .clk         (clk),
        .rst         (rst),
        .req_here_i  (req_here),
        .done_here_i (done_here),
        .pos_o       (pos),
        .phase_o     (phase)
    );

    tring_decode #(.NODES(NODES)) u_decode (
        .pos_i   (pos),
        .phase_i (phase),
        .grant_o (grant_o),
        .token_o (token_o)
    );

endmodule

// File: rtl/tring_checker.sv
module tring_checker #(
    parameter int NODES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [NODES-1:0] req_i,
    input logic [NODES-1:0] done_i,
    input logic [NODES-1:0] grant_o,
    input logic [NODES-1:0] token_o
);

    function automatic logic [NODES-1:0] rot1(logic [NODES-1:0] v);
        return {v[NODES-2:0], v[NODES-1]};
    endfunction

    assert_grant_onehot0_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    assert_token_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot(token_o));

    assert_grant_at_token_R10: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~token_o) == '0);

    assert_skip_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (grant_o == '0 && (token_o & req_i) == '0)
        |=> (grant_o == '0 && token_o == rot1($past(token_o))));

    assert_seize_R3: assert property (@(posedge clk) disable iff (rst)
        (grant_o == '0 && (token_o & req_i) != '0)
        |=> grant_o == $past(token_o));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (grant_o != '0 && (grant_o & done_i) == '0)
        |=> (grant_o == $past(grant_o) && token_o == $past(token_o)));

    assert_handoff_R5: assert property (@(posedge clk) disable iff (rst)
        ((grant_o & done_i) != '0)
        |=> (grant_o == '0 && token_o == rot1($past(token_o))));

endmodule

bind token_ring_arbiter tring_checker #(.NODES(NODES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .done_i  (done_i),
    .grant_o (grant_o),
    .token_o (token_o)
);

// File: tb/token_ring_arbiter_bench.sv
module token_ring_arbiter_bench;

    localparam int N = 4;
    localparam time HALF = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] done_i = '0;
    logic [N-1:0] grant_o;
    logic [N-1:0] token_o;

    token_ring_arbiter #(.NODES(N)) u_token_ring_arbiter (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_i),
        .done_i  (done_i),
        .grant_o (grant_o),
        .token_o (token_o)
    );

    always #HALF clk = ~clk;

    typedef struct {
        logic [N-1:0] tok;
        logic [N-1:0] gnt;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    // Bench model of token custody, built from the requirements.
    int m_pos = 0;
    bit m_own = 1'b0;

    task automatic step(input logic r, input logic [N-1:0] rq,
                        input logic [N-1:0] dn, input string tag);
        exp_t e;
        @(negedge clk);
        rst    = r;
        req_i  = rq;
        done_i = dn;
        if (r) begin
            m_pos = 0;
            m_own = 1'b0;
        end else if (m_own) begin
            if (dn[m_pos]) begin
                m_own = 1'b0;
                m_pos = (m_pos + 1) % N;
            end
        end else if (rq[m_pos]) begin
            m_own = 1'b1;
        end else begin
            m_pos = (m_pos + 1) % N;
        end
        e.tok = N'(1) << m_pos;
        e.gnt = m_own ? e.tok : '0;
        e.tag = tag;
        sb.push_back(e);
    endtask

    function automatic logic [N-1:0] holder_bit();
        return N'(1) << m_pos;
    endfunction

    // Monitor: compares outputs shortly after each rising edge.
    always @(posedge clk) begin
        #2ns;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (token_o !== e.tok || grant_o !== e.gnt) begin
                errors++;
                $display("FAIL %s: token=%b grant=%b expected token=%b grant=%b",
                         e.tag, token_o, grant_o, e.tok, e.gnt);
            end
        end
    end

    initial begin
        #(200000 * 2 * HALF);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1'b1, '0, '0, "R1 reset");
        step(1'b1, 4'b1111, 4'b1111, "R1 reset ignores inputs");
        // R2 and R8: idle rotation with wrap
        for (int i = 0; i < 6; i++) step(1'b0, '0, '0, "R2 R8 idle rotation");
        // R3, R4, R6, R5: every node requests; full rounds of ownership
        for (int k = 0; k < 5; k++) begin
            step(1'b0, 4'b1111, '0, "R3 seize");
            step(1'b0, 4'b1111, '0, "R4 hold");
            step(1'b0, 4'b1111, ~holder_bit(), "R6 stray done ignored");
            step(1'b0, 4'b1111, '0, "R4 hold after stray");
            step(1'b0, 4'b1111, holder_bit(), "R5 R8 hand-off");
        end
        // R10 and R7: only node 2 requests
        for (int i = 0; i < 6; i++) step(1'b0, 4'b0100, '0, "R10 R7 single requester");
        // R4: request dropped mid-grant, grant held
        for (int i = 0; i < 3; i++) step(1'b0, 4'b0000, '0, "R4 request dropped");
        step(1'b0, 4'b0000, holder_bit(), "R5 release after drop");
        step(1'b0, 4'b0000, '0, "R9 R2 after release");
        // R6: done pulses while no grant is held
        for (int i = 0; i < 4; i++) step(1'b0, 4'b0000, 4'b1111, "R6 done without grant");
        // Adjacent requesters; R8 ordering
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 4'b1001, '0, "R8 R3 neighbours");
            step(1'b0, 4'b1001, '0, "R8 R4 neighbours");
            step(1'b0, 4'b1001, holder_bit(), "R8 R5 neighbours");
        end
        // R1: reset again mid-operation
        step(1'b1, 4'b1111, '0, "R1 reset mid-run");
        step(1'b0, '0, '0, "R1 R2 after reset");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule